// File: doc/BRIEF.md
# Variable Block Size SAD Pipeline

This block computes the distortion of one search candidate for every partition of a 16x16 macroblock: sixteen 4x4 blocks, eight 8x4, eight 4x8, four 8x8, two 16x8, two 8x16 and the whole 16x16 block, 41 sums of absolute differences in total. Each clock it takes one 16-pixel row of the current macroblock and the matching 16-pixel row of the candidate block. After sixteen valid rows every sub-block distortion has been delivered.

Larger sums are never recomputed from pixels. A first stage accumulates four column groups over four rows to form 4x4 sums. A second stage combines these horizontally into 8x4 sums and vertically into 4x8 sums, keeping the upper band in holding registers. A third stage builds 8x8 and 16x8 sums from the 4x8 sums and keeps the upper 8x8 pair to finish the 8x16 and 16x16 sums. The second and third stages only load on a strobe, once every four and once every eight rows. Their logic therefore has a multi-cycle window to settle, and every result stays on its port until the next strobe of its kind. A downstream minimum search can sample it at any time in between. Candidates may follow each other with no idle cycle.

Top module: `vbs_sad_pipe`

## Requirements
- R1: Pixel i of a row sits at bits [PIX_W*i+PIX_W-1 : PIX_W*i] of `cur_row` and `ref_row`. Column group g covers pixels 4g to 4g+3. Lane g of `sad4x4` (bits [W4*g+W4-1 : W4*g], W4 = PIX_W+4) is the 4x4 sum of column group g over the four rows of band b = row/4. `sad4x4_band` shows b. `sad4x4_vld` pulses in the cycle after the edge that samples row 3, 7, 11 or 15.
- R2: Lane k of `sad8x4` is the sum of 4x4 lanes 2k and 2k+1 of the same band. It pulses `sad8x4_vld` one cycle after `sad4x4_vld` and repeats the band on `sad8x4_band`.
- R3: Only after bands 1 and 3, lane g of `sad4x8` is the sum of lane g of band 2h and band 2h+1, where h is the half. The half is shown on `sad4x8_half`, and `sad4x8_vld` pulses in the same cycle as `sad8x4_vld`.
- R4: Lane j of `sad8x8` is the sum of 4x8 lanes 2j and 2j+1. `sad16x8` is the sum of all four 4x8 lanes. Both pulse one cycle after `sad4x8_vld` and carry the half on their own half outputs.
- R5: Lane j of `sad8x16` is lane j of the 8x8 sums of both halves added together. `sad16x16` is the sum over all 16 rows. Both pulse together with the second-half 8x8 strobe, three cycles after the edge that samples row 15.
- R6: Every strobe lasts one cycle. Every value, band and half output holds unchanged between two strobes of its own kind.
- R7: `row_first` sampled with `row_vld` makes that row row 0 and abandons any unfinished candidate.
- R8: Without `row_first`, the row after row 15 is row 0 of the next candidate. Candidates can be sent back to back with no idle cycle.
- R9: While `row_vld` is low, nothing advances. Pixel inputs and `row_first` are ignored.
- R10: During and straight after reset all strobes are low, all values are 0, and the next valid row is row 0.
- R11: Nothing saturates or wraps. Widths are PIX_W+4 for 4x4, +5 for 8x4 and 4x8, +6 for 8x8, +7 for 16x8 and 8x16, and +8 for 16x16. With PIX_W = 8 the largest differences give 4080 and 65280.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_vld | input | 1 | A row pair is present this cycle |
| row_first | input | 1 | This row is row 0 of a new candidate |
| cur_row | input | 16*PIX_W | Current-macroblock row |
| ref_row | input | 16*PIX_W | Candidate-block row |
| sad4x4 | output | 4*(PIX_W+4) | Four 4x4 sums of one band |
| sad4x4_band | output | 2 | Band of the 4x4 sums |
| sad4x4_vld | output | 1 | 4x4 strobe |
| sad8x4 | output | 2*(PIX_W+5) | Two 8x4 sums of one band |
| sad8x4_band | output | 2 | Band of the 8x4 sums |
| sad8x4_vld | output | 1 | 8x4 strobe |
| sad4x8 | output | 4*(PIX_W+5) | Four 4x8 sums of one half |
| sad4x8_half | output | 1 | Half of the 4x8 sums |
| sad4x8_vld | output | 1 | 4x8 strobe |
| sad8x8 | output | 2*(PIX_W+6) | Two 8x8 sums of one half |
| sad8x8_half | output | 1 | Half of the 8x8 sums |
| sad8x8_vld | output | 1 | 8x8 strobe |
| sad16x8 | output | PIX_W+7 | 16x8 sum of one half |
| sad16x8_half | output | 1 | Half of the 16x8 sum |
| sad16x8_vld | output | 1 | 16x8 strobe |
| sad8x16 | output | 2*(PIX_W+7) | Left and right 8x16 sums |
| sad8x16_vld | output | 1 | 8x16 strobe |
| sad16x16 | output | PIX_W+8 | Whole-macroblock sum |
| sad16x16_vld | output | 1 | 16x16 strobe |

## Verification
The bench builds the block with its default 8-bit pixels. At that width, opposite pixel extremes drive every sum to its full width, so a dropped carry in any stage shows up as a wrong 4080 or 65280. Idle gaps inside candidates, aborted candidates and row-counter wraparound are mixed with random, ramp and zero-distortion rows. These cases reach the holding registers of stages two and three along every path that can refill or bypass them.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    // Macroblock geometry: a 16x16 block tiled by 4x4 sub-blocks.
    localparam int MB_DIM    = 16;
    localparam int SUB_DIM   = 4;
    localparam int LANES     = MB_DIM / SUB_DIM;
    localparam int PAIRS     = LANES / 2;
    localparam int ROW_W     = $clog2(MB_DIM);
    localparam int SUB_W     = $clog2(SUB_DIM);
    localparam int BAND_W    = $clog2(LANES);
    localparam int MAX_PIX_W = 16;

    typedef logic [ROW_W-1:0] row_idx_t;

    // Strobe plus position tag travelling with a group of sums.
    typedef struct packed {
        logic              vld;
        logic [BAND_W-1:0] band;
    } band_tag_t;

    typedef struct packed {
        logic vld;
        logic half;
    } half_tag_t;

    // Unsigned absolute difference, no sign extension needed.
    function automatic logic [MAX_PIX_W-1:0] abs_diff(
        input logic [MAX_PIX_W-1:0] a,
        input logic [MAX_PIX_W-1:0] b
    );
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/vbs_row_acc.sv
// Stage 1: per-row absolute differences, four column groups, four-row accumulation.
module vbs_row_acc
    import vbs_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ACC_W = PIX_W + 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     row_vld,
    input  logic                     row_first,
    input  logic [MB_DIM*PIX_W-1:0]  cur_row,
    input  logic [MB_DIM*PIX_W-1:0]  ref_row,
    output logic [LANES*ACC_W-1:0]   sad4_q,
    output band_tag_t                sad4_tag
);

    localparam int PART_W = PIX_W + SUB_W;

    row_idx_t nxt_row;
    row_idx_t row_idx;
    logic     band_start;
    logic     band_end;

    assign row_idx    = row_first ? '0 : nxt_row;
    assign band_start = (row_idx[SUB_W-1:0] == '0);
    assign band_end   = (row_idx[SUB_W-1:0] == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_row <= '0;
        end else if (row_vld) begin
            nxt_row <= row_idx + 1'b1;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PART_W-1:0] part;
        logic [ACC_W-1:0]  acc;
        logic [ACC_W-1:0]  lane_sad;

        always_comb begin
            part = '0;
            for (int k = 0; k < SUB_DIM; k++) begin
                part = part + PART_W'(abs_diff(
                    MAX_PIX_W'(cur_row[(g*SUB_DIM+k)*PIX_W +: PIX_W]),
                    MAX_PIX_W'(ref_row[(g*SUB_DIM+k)*PIX_W +: PIX_W])));
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                acc      <= '0;
                lane_sad <= '0;
            end else if (row_vld) begin
                acc <= band_start ? ACC_W'(part) : acc + ACC_W'(part);
                if (band_end) begin
                    lane_sad <= acc + ACC_W'(part);
                end
            end
        end

        assign sad4_q[g*ACC_W +: ACC_W] = lane_sad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sad4_tag <= '0;
        end else begin
            sad4_tag.vld <= row_vld && band_end;
            if (row_vld && band_end) begin
                sad4_tag.band <= row_idx[ROW_W-1:SUB_W];
            end
        end
    end

endmodule

// File: rtl/vbs_band_merge.sv
// Stage 2: horizontal pairs (8x4) and vertical pairs (4x8) of 4x4 sums.
// Loads only on the 4x4 strobe, so its inputs are steady for four rows.
module vbs_band_merge
    import vbs_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = IN_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES*IN_W-1:0]   sad4_q,
    input  band_tag_t               sad4_tag,
    output logic [PAIRS*OUT_W-1:0]  sad84_q,
    output band_tag_t               sad84_tag,
    output logic [LANES*OUT_W-1:0]  sad48_q,
    output half_tag_t               sad48_tag
);

    logic lower_band;
    assign lower_band = sad4_tag.band[0];

    for (genvar k = 0; k < PAIRS; k++) begin : g_wide
        logic [OUT_W-1:0] wide_sad;
        always_ff @(posedge clk) begin
            if (rst) begin
                wide_sad <= '0;
            end else if (sad4_tag.vld) begin
                wide_sad <= OUT_W'(sad4_q[(2*k)*IN_W +: IN_W])
                          + OUT_W'(sad4_q[(2*k+1)*IN_W +: IN_W]);
            end
        end
        assign sad84_q[k*OUT_W +: OUT_W] = wide_sad;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_tall
        logic [IN_W-1:0]  upper_hold;
        logic [OUT_W-1:0] tall_sad;
        always_ff @(posedge clk) begin
            if (rst) begin
                upper_hold <= '0;
                tall_sad   <= '0;
            end else if (sad4_tag.vld) begin
                if (lower_band) begin
                    tall_sad <= OUT_W'(upper_hold) + OUT_W'(sad4_q[g*IN_W +: IN_W]);
                end else begin
                    upper_hold <= sad4_q[g*IN_W +: IN_W];
                end
            end
        end
        assign sad48_q[g*OUT_W +: OUT_W] = tall_sad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sad84_tag <= '0;
            sad48_tag <= '0;
        end else begin
            sad84_tag.vld <= sad4_tag.vld;
            sad48_tag.vld <= sad4_tag.vld && lower_band;
            if (sad4_tag.vld) begin
                sad84_tag.band <= sad4_tag.band;
            end
            if (sad4_tag.vld && lower_band) begin
                sad48_tag.half <= sad4_tag.band[BAND_W-1];
            end
        end
    end

endmodule

// File: rtl/vbs_half_merge.sv
// Stage 3: 8x8 and 16x8 from 4x8 sums; 8x16 and 16x16 from both halves.
// Loads only on the 4x8 strobe, so its inputs are steady for eight rows.
module vbs_half_merge
    import vbs_pkg::*;
#(
    parameter int IN_W   = 13,
    parameter int W88    = IN_W + 1,
    parameter int W168   = IN_W + 2,
    parameter int W816   = IN_W + 2,
    parameter int W1616  = IN_W + 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES*IN_W-1:0]  sad48_q,
    input  half_tag_t              sad48_tag,
    output logic [PAIRS*W88-1:0]   sad88_q,
    output half_tag_t              sad88_tag,
    output logic [W168-1:0]        sad168_q,
    output half_tag_t              sad168_tag,
    output logic [PAIRS*W816-1:0]  sad816_q,
    output logic                   sad816_vld,
    output logic [W1616-1:0]       sad1616_q,
    output logic                   sad1616_vld
);

    logic [W88-1:0]   quad   [PAIRS];
    logic [W88-1:0]   held   [PAIRS];
    logic [W168-1:0]  band_sum;
    logic [W168-1:0]  held_sum;
    logic             low_half;

    assign low_half = sad48_tag.half;

    always_comb begin
        band_sum = '0;
        held_sum = '0;
        for (int j = 0; j < PAIRS; j++) begin
            quad[j]  = W88'(sad48_q[(2*j)*IN_W +: IN_W])
                     + W88'(sad48_q[(2*j+1)*IN_W +: IN_W]);
            band_sum = band_sum + W168'(quad[j]);
            held_sum = held_sum + W168'(held[j]);
        end
    end

    for (genvar j = 0; j < PAIRS; j++) begin : g_quad
        logic [W88-1:0]  sq_sad;
        logic [W816-1:0] col_sad;
        always_ff @(posedge clk) begin
            if (rst) begin
                sq_sad  <= '0;
                held[j] <= '0;
                col_sad <= '0;
            end else if (sad48_tag.vld) begin
                sq_sad <= quad[j];
                if (low_half) begin
                    col_sad <= W816'(held[j]) + W816'(quad[j]);
                end else begin
                    held[j] <= quad[j];
                end
            end
        end
        assign sad88_q[j*W88 +: W88]     = sq_sad;
        assign sad816_q[j*W816 +: W816]  = col_sad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sad168_q    <= '0;
            sad1616_q   <= '0;
            sad88_tag   <= '0;
            sad168_tag  <= '0;
            sad816_vld  <= 1'b0;
            sad1616_vld <= 1'b0;
        end else begin
            sad88_tag.vld  <= sad48_tag.vld;
            sad168_tag.vld <= sad48_tag.vld;
            sad816_vld     <= sad48_tag.vld && low_half;
            sad1616_vld    <= sad48_tag.vld && low_half;
            if (sad48_tag.vld) begin
                sad88_tag.half  <= low_half;
                sad168_tag.half <= low_half;
                sad168_q        <= band_sum;
                if (low_half) begin
                    sad1616_q <= W1616'(held_sum) + W1616'(band_sum);
                end
            end
        end
    end

endmodule

// File: rtl/vbs_sad_pipe.sv
// Top: three-stage variable block size SAD pipeline for one search candidate.
module vbs_sad_pipe
    import vbs_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          row_vld,
    input  logic                          row_first,
    input  logic [MB_DIM*PIX_W-1:0]       cur_row,
    input  logic [MB_DIM*PIX_W-1:0]       ref_row,
    output logic [LANES*(PIX_W+4)-1:0]    sad4x4,
    output logic [BAND_W-1:0]             sad4x4_band,
    output logic                          sad4x4_vld,
    output logic [PAIRS*(PIX_W+5)-1:0]    sad8x4,
    output logic [BAND_W-1:0]             sad8x4_band,
    output logic                          sad8x4_vld,
    output logic [LANES*(PIX_W+5)-1:0]    sad4x8,
    output logic                          sad4x8_half,
    output logic                          sad4x8_vld,
    output logic [PAIRS*(PIX_W+6)-1:0]    sad8x8,
    output logic                          sad8x8_half,
    output logic                          sad8x8_vld,
    output logic [PIX_W+6:0]              sad16x8,
    output logic                          sad16x8_half,
    output logic                          sad16x8_vld,
    output logic [PAIRS*(PIX_W+7)-1:0]    sad8x16,
    output logic                          sad8x16_vld,
    output logic [PIX_W+7:0]              sad16x16,
    output logic                          sad16x16_vld
);

    localparam int W4    = PIX_W + 2*SUB_W;
    localparam int W84   = W4 + 1;
    localparam int W88   = W4 + 2;
    localparam int W168  = W4 + 3;
    localparam int W1616 = W4 + 4;

    band_tag_t t4;
    band_tag_t t84;
    half_tag_t t48;
    half_tag_t t88;
    half_tag_t t168;

    vbs_row_acc #(
        .PIX_W (PIX_W),
        .ACC_W (W4)
    ) u_row_acc (
        .clk       (clk),
        .rst       (rst),
        .row_vld   (row_vld),
        .row_first (row_first),
        .cur_row   (cur_row),
        .ref_row   (ref_row),
        .sad4_q    (sad4x4),
        .sad4_tag  (t4)
    );

    vbs_band_merge #(
        .IN_W  (W4),
        .OUT_W (W84)
    ) u_band_merge (
        .clk       (clk),
        .rst       (rst),
        .sad4_q    (sad4x4),
        .sad4_tag  (t4),
        .sad84_q   (sad8x4),
        .sad84_tag (t84),
        .sad48_q   (sad4x8),
        .sad48_tag (t48)
    );

    vbs_half_merge #(
        .IN_W  (W84),
        .W88   (W88),
        .W168  (W168),
        .W816  (W168),
        .W1616 (W1616)
    ) u_half_merge (
        .clk         (clk),
        .rst         (rst),
        .sad48_q     (sad4x8),
        .sad48_tag   (t48),
        .sad88_q     (sad8x8),
        .sad88_tag   (t88),
        .sad168_q    (sad16x8),
        .sad168_tag  (t168),
        .sad816_q    (sad8x16),
        .sad816_vld  (sad8x16_vld),
        .sad1616_q   (sad16x16),
        .sad1616_vld (sad16x16_vld)
    );

    assign sad4x4_band  = t4.band;
    assign sad4x4_vld   = t4.vld;
    assign sad8x4_band  = t84.band;
    assign sad8x4_vld   = t84.vld;
    assign sad4x8_half  = t48.half;
    assign sad4x8_vld   = t48.vld;
    assign sad8x8_half  = t88.half;
    assign sad8x8_vld   = t88.vld;
    assign sad16x8_half = t168.half;
    assign sad16x8_vld  = t168.vld;

endmodule

// File: rtl/vbs_sad_chk.sv
module vbs_sad_chk #(
    parameter int PIX_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    row_vld,
    input logic [4*(PIX_W+4)-1:0]  sad4x4,
    input logic                    sad4x4_vld,
    input logic [2*(PIX_W+5)-1:0]  sad8x4,
    input logic                    sad8x4_vld,
    input logic                    sad8x16_vld,
    input logic                    sad16x8_half,
    input logic                    sad16x8_vld,
    input logic [PIX_W+7:0]        sad16x16,
    input logic                    sad16x16_vld
);

    localparam int W4  = PIX_W + 4;
    localparam int W84 = PIX_W + 5;

    // R1
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        sad4x4_vld |=> !sad4x4_vld);

    // R2
    wide_follow_chk: assert property (@(posedge clk) disable iff (rst)
        sad4x4_vld |=> sad8x4_vld);

    // R2
    wide_sum_chk: assert property (@(posedge clk) disable iff (rst)
        sad8x4_vld |-> sad8x4[W84-1:0] ==
            W84'($past(sad4x4[W4-1:0])) + W84'($past(sad4x4[2*W4-1:W4])));

    // R5
    full_pair_chk: assert property (@(posedge clk) disable iff (rst)
        sad16x16_vld |-> sad8x16_vld);

    // R5
    full_after_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (sad16x8_vld && sad16x8_half) |-> sad16x16_vld);

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sad16x16_vld |-> $stable(sad16x16));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !row_vld |=> !sad4x4_vld);

endmodule

bind vbs_sad_pipe vbs_sad_chk #(.PIX_W(PIX_W)) u_sad_chk (
    .clk          (clk),
    .rst          (rst),
    .row_vld      (row_vld),
    .sad4x4       (sad4x4),
    .sad4x4_vld   (sad4x4_vld),
    .sad8x4       (sad8x4),
    .sad8x4_vld   (sad8x4_vld),
    .sad8x16_vld  (sad8x16_vld),
    .sad16x8_half (sad16x8_half),
    .sad16x8_vld  (sad16x8_vld),
    .sad16x16     (sad16x16),
    .sad16x16_vld (sad16x16_vld)
);

// File: tb/tb_vbs_sad_pipe.sv
module tb_vbs_sad_pipe;

    localparam int PIX_W = 8;
    localparam int W4    = PIX_W + 4;
    localparam int W84   = PIX_W + 5;
    localparam int W88   = PIX_W + 6;
    localparam int W168  = PIX_W + 7;
    localparam int W1616 = PIX_W + 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst;
    logic                 row_vld;
    logic                 row_first;
    logic [16*PIX_W-1:0]  cur_row;
    logic [16*PIX_W-1:0]  ref_row;
    logic [4*W4-1:0]      sad4x4;
    logic [1:0]           sad4x4_band;
    logic                 sad4x4_vld;
    logic [2*W84-1:0]     sad8x4;
    logic [1:0]           sad8x4_band;
    logic                 sad8x4_vld;
    logic [4*W84-1:0]     sad4x8;
    logic                 sad4x8_half;
    logic                 sad4x8_vld;
    logic [2*W88-1:0]     sad8x8;
    logic                 sad8x8_half;
    logic                 sad8x8_vld;
    logic [W168-1:0]      sad16x8;
    logic                 sad16x8_half;
    logic                 sad16x8_vld;
    logic [2*W168-1:0]    sad8x16;
    logic                 sad8x16_vld;
    logic [W1616-1:0]     sad16x16;
    logic                 sad16x16_vld;

    vbs_sad_pipe #(.PIX_W(PIX_W)) dut (
        .clk(clk), .rst(rst), .row_vld(row_vld), .row_first(row_first),
        .cur_row(cur_row), .ref_row(ref_row),
        .sad4x4(sad4x4), .sad4x4_band(sad4x4_band), .sad4x4_vld(sad4x4_vld),
        .sad8x4(sad8x4), .sad8x4_band(sad8x4_band), .sad8x4_vld(sad8x4_vld),
        .sad4x8(sad4x8), .sad4x8_half(sad4x8_half), .sad4x8_vld(sad4x8_vld),
        .sad8x8(sad8x8), .sad8x8_half(sad8x8_half), .sad8x8_vld(sad8x8_vld),
        .sad16x8(sad16x8), .sad16x8_half(sad16x8_half), .sad16x8_vld(sad16x8_vld),
        .sad8x16(sad8x16), .sad8x16_vld(sad8x16_vld),
        .sad16x16(sad16x16), .sad16x16_vld(sad16x16_vld)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic cmp(input int act, input int exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // ---------------- behavioural reference model ----------------
    int p [16][4];
    int m_nxt;
    int e4 [4];   int e4b;  bit e4v;
    int e84 [2];  int e84b; bit e84v;
    int e48 [4];  int e48h; bit e48v;
    int e88 [2];  int e88h; bit e88v;
    int e168;     int e168h; bit e168v;
    int e816 [2]; bit e816v;
    int e1616;    bit e1616v;
    int s84 [2];  int s84b;
    int s48 [4];  int s48h; bit s48on;
    int s88 [2];  int s168; bit s3full;
    int s816 [2]; int s1616;
    int d2, d3;
    bit live = 0;

    always @(posedge clk) begin
        int r;
        int b;
        live = 1;
        e4v = 0; e84v = 0; e48v = 0; e88v = 0; e168v = 0; e816v = 0; e1616v = 0;
        if (rst) begin
            m_nxt = 0; d2 = 0; d3 = 0;
            e4b = 0; e84b = 0; e48h = 0; e88h = 0; e168h = 0; e168 = 0; e1616 = 0;
            for (int i = 0; i < 4; i++) begin e4[i] = 0; e48[i] = 0; end
            for (int i = 0; i < 2; i++) begin e84[i] = 0; e88[i] = 0; e816[i] = 0; end
        end else begin
            if (d2 > 0) begin
                d2--;
                if (d2 == 0) begin
                    e84 = s84; e84b = s84b; e84v = 1;
                    if (s48on) begin e48 = s48; e48h = s48h; e48v = 1; end
                end
            end
            if (d3 > 0) begin
                d3--;
                if (d3 == 0 && s48on) begin
                    e88 = s88; e88h = s48h; e88v = 1;
                    e168 = s168; e168h = s48h; e168v = 1;
                    if (s3full) begin e816 = s816; e1616 = s1616; e816v = 1; e1616v = 1; end
                end
            end
            if (row_vld) begin
                r = row_first ? 0 : m_nxt;
                m_nxt = (r + 1) % 16;
                for (int g = 0; g < 4; g++) begin
                    p[r][g] = 0;
                    for (int k = 0; k < 4; k++)
                        p[r][g] += absd(int'(cur_row[(4*g+k)*PIX_W +: PIX_W]),
                                        int'(ref_row[(4*g+k)*PIX_W +: PIX_W]));
                end
                if (r % 4 == 3) begin
                    b = r / 4;
                    for (int g = 0; g < 4; g++) begin
                        e4[g] = 0;
                        for (int k = b*4; k < b*4+4; k++) e4[g] += p[k][g];
                    end
                    e4b = b; e4v = 1;
                    for (int k = 0; k < 2; k++) s84[k] = e4[2*k] + e4[2*k+1];
                    s84b = b;
                    s48on = (b % 2 == 1);
                    s48h = b / 2;
                    s3full = (b == 3);
                    s168 = 0;
                    for (int g = 0; g < 4; g++) begin
                        s48[g] = 0;
                        if (s48on) for (int k = (b-1)*4; k < b*4+4; k++) s48[g] += p[k][g];
                    end
                    for (int j = 0; j < 2; j++) begin
                        s88[j] = s48[2*j] + s48[2*j+1];
                        s168 += s88[j];
                        s816[j] = 0;
                        for (int k = 0; k < 16; k++) s816[j] += p[k][2*j] + p[k][2*j+1];
                    end
                    s1616 = s816[0] + s816[1];
                    d2 = 1; d3 = 2;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (live && !done) begin
            cmp(int'(sad4x4_vld), int'(e4v), "R1 4x4 strobe");
            cmp(int'(sad4x4_band), e4b, "R1 4x4 band");
            for (int g = 0; g < 4; g++) cmp(int'(sad4x4[g*W4 +: W4]), e4[g], "R1 4x4 lane");
            cmp(int'(sad8x4_vld), int'(e84v), "R2 8x4 strobe");
            cmp(int'(sad8x4_band), e84b, "R2 8x4 band");
            for (int k = 0; k < 2; k++) cmp(int'(sad8x4[k*W84 +: W84]), e84[k], "R2 8x4 lane");
            cmp(int'(sad4x8_vld), int'(e48v), "R3 4x8 strobe");
            cmp(int'(sad4x8_half), e48h, "R3 4x8 half");
            for (int g = 0; g < 4; g++) cmp(int'(sad4x8[g*W84 +: W84]), e48[g], "R3 4x8 lane");
            cmp(int'(sad8x8_vld), int'(e88v), "R4 8x8 strobe");
            cmp(int'(sad8x8_half), e88h, "R4 8x8 half");
            for (int j = 0; j < 2; j++) cmp(int'(sad8x8[j*W88 +: W88]), e88[j], "R4 8x8 lane");
            cmp(int'(sad16x8_vld), int'(e168v), "R4 16x8 strobe");
            cmp(int'(sad16x8_half), e168h, "R4 16x8 half");
            cmp(int'(sad16x8), e168, "R4 16x8 value");
            cmp(int'(sad8x16_vld), int'(e816v), "R5 8x16 strobe");
            for (int j = 0; j < 2; j++) cmp(int'(sad8x16[j*W168 +: W168]), e816[j], "R5 8x16 lane");
            cmp(int'(sad16x16_vld), int'(e1616v), "R5 16x16 strobe");
            cmp(int'(sad16x16), e1616, "R5 16x16 value");
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [PIX_W-1:0] pix(input int kind, input int seed,
                                             input int r, input int c, input int w);
        int unsigned h;
        case (kind)
            1: return PIX_W'(r*16 + c);
            2: return w ? '1 : '0;
            3: return w ? '0 : '1;
            4: return w ? PIX_W'(c*16) : PIX_W'(r*16);
            default: begin
                h = (seed * 32'h9E3779B1) ^ ((r*131 + c*17 + w*7919) * 32'h85EBCA6B);
                h = h ^ (h >> 13);
                return PIX_W'(h >> 5);
            end
        endcase
    endfunction

    task automatic idle();
        @(negedge clk);
        row_vld   = 1'b0;
        row_first = 1'b1;
        cur_row   = ~cur_row;
        ref_row   = {ref_row[PIX_W-1:0], ref_row[16*PIX_W-1:PIX_W]};
    endtask

    task automatic run_cand(input int kind, input int seed, input int gap_mod,
                            input bit mark_first, input int nrows);
        for (int r = 0; r < nrows; r++) begin
            if (gap_mod > 0 && ((r*7 + seed) % gap_mod) == 0)
                for (int i = 0; i < (r % 3) + 1; i++) idle();
            @(negedge clk);
            row_vld   = 1'b1;
            row_first = mark_first && (r == 0);
            for (int c = 0; c < 16; c++) begin
                cur_row[c*PIX_W +: PIX_W] = pix(kind, seed, r, c, 0);
                ref_row[c*PIX_W +: PIX_W] = pix(kind, seed, r, c, 1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; row_vld = 1'b0; row_first = 1'b0; cur_row = '0; ref_row = '0;
        repeat (4) @(negedge clk);
        // R10 reset state
        cmp(int'(sad4x4_vld), 0, "R10 4x4 strobe in reset");
        cmp(int'(sad16x16_vld), 0, "R10 16x16 strobe in reset");
        cmp(int'(sad16x16), 0, "R10 16x16 value in reset");
        cmp(int'(sad4x4), 0, "R10 4x4 value in reset");
        rst = 1'b0;

        // R10: first row after reset without row_first still counts as row 0
        run_cand(0, 11, 0, 1'b0, 16);
        run_cand(0, 12, 0, 1'b1, 16);
        run_cand(4, 0, 0, 1'b1, 16);

        // R11 extreme differences
        run_cand(2, 0, 0, 1'b1, 16);
        idle(); idle(); idle();
        cmp(int'(sad16x16_vld), 1, "R11 16x16 strobe at full scale");
        cmp(int'(sad16x16), 65280, "R11 16x16 full scale");
        cmp(int'(sad4x4[0 +: W4]), 4080, "R11 4x4 full scale");
        cmp(int'(sad8x16[W168 +: W168]), 32640, "R11 8x16 full scale");

        // R6 hold between strobes
        repeat (5) idle();
        cmp(int'(sad16x16_vld), 0, "R6 16x16 strobe low");
        cmp(int'(sad16x16), 65280, "R6 16x16 held");
        cmp(int'(sad8x8[0 +: W88]), 16320, "R6 8x8 held");

        // R7 abort: six rows then a restart with zero distortion
        run_cand(0, 21, 0, 1'b1, 6);
        run_cand(1, 0, 0, 1'b1, 16);
        idle(); idle(); idle();
        cmp(int'(sad16x16_vld), 1, "R7 16x16 strobe after restart");
        cmp(int'(sad16x16), 0, "R7 16x16 after restart");
        cmp(int'(sad8x16), 0, "R7 8x16 after restart");

        // R8 wraparound: second candidate sent with no row_first, no gap
        run_cand(0, 31, 0, 1'b1, 16);
        run_cand(3, 0, 0, 1'b0, 16);
        idle(); idle(); idle();
        cmp(int'(sad16x16), 65280, "R8 16x16 of wrapped candidate");
        cmp(int'(sad16x16_vld), 1, "R8 16x16 strobe of wrapped candidate");

        // R9 idle gaps inside candidates, garbage on inputs while idle
        for (int s = 0; s < 4; s++) run_cand(0, 40 + s, 3, 1'b1, 16);
        idle(); idle(); idle();
        cmp(int'(sad16x16), e1616, "R9 16x16 with stalls");
        cmp(int'(sad8x16[0 +: W168]), e816[0], "R9 8x16 with stalls");

        // back-to-back random candidates
        for (int s = 0; s < 20; s++) run_cand(0, 100 + s, 0, s[0], 16);
        repeat (8) idle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule